// File: doc/BRIEF.md
# Triplex LCD Multiplex Scanner

This block produces the digital drive pattern for a liquid crystal panel that is multiplexed three ways: three backplane lines and twelve segment lines, which together address 36 display points. A 36-bit display image comes from external latches. The block copies that image once per frame. It then walks through three backplane phases and gives every line a 2-bit code, and an analog stage outside the block turns each code into one of four voltages. Each phase has a positive half and a mirrored negative half, so the average drive on every line is zero over a frame.

Time is counted in scan ticks. In stand-alone, master and reserved modes a tick is one cycle of `osc_tick_i`, which comes from an oscillator divider outside the block. In slave mode a tick is each transition of `ext_clk_i`, which carries the scan clock of a master device. The mode also sets the role of two pins. Pin A either drives a backplane or serves as the clock input. Pin C either drives a backplane or carries the scan clock for devices further down a cascade.

Top module: `lcd_triplex_scan`

## Requirements
- R1: A frame lasts 3*PHASE_TICKS scan ticks (192 by default). The phases run in the order A, B, C, each PHASE_TICKS ticks long. Within a phase, the first PHASE_TICKS/2 ticks are the positive half and the rest are the negative half.
- R2: Level codes are 0=low, 1=mid-low, 2=mid-high, 3=high. In the positive half the active backplane is high and the other backplanes are mid-low. In the negative half the active backplane is low and the others are mid-high.
- R3: A lit segment is driven opposite to the active backplane: low in the positive half, high in the negative half. An unlit segment is mid-high in the positive half and mid-low in the negative half.
- R4: For digit d (0..3), take offset k = image bit minus 8d. Line SA_d shows k=6 in phase A, k=5 in phase B and k=0 in phase C. Line SB_d shows k=7 in A, k=1 in B and k=4 in C. Line SC_d shows k=2 in A and k=3 in B.
- R5: Image bit 32+d drives line SC_d during phase C.
- R6: Segment line l (0=SA, 1=SB, 2=SC) of digit d appears on `seg_o[2*(3*d+l)+1 : 2*(3*d+l)]`.
- R7: The image is copied only on the tick that ends a frame, using the value present on that tick. A change of `image_i` at any other time leaves the current frame's segment codes unchanged.
- R8: After reset the scan position is phase A, positive half, tick 0. The image copy is all zeros and the scan clock is 0.
- R9: Mode 01 (stand-alone): ticks come from `osc_tick_i`. Pins A and C both drive backplanes, `bp_a_oe_o`=1 and `pin_c_clk_o`=0.
- R10: Mode 00 (master): ticks come from `osc_tick_i`. `scan_clk_o` toggles on every tick, `pin_c_clk_o`=1, and `bp_c_o` shows the scan clock as high or low. Pin A drives its backplane.
- R11: Mode 11 (slave): each transition of `ext_clk_i` advances the scan by one tick, three clock edges later, and `osc_tick_i` is ignored. Pin A is an input, so `bp_a_oe_o`=0 and `bp_a_o`=0, and pin C drives its backplane.
- R12: Mode 10 (reserved): ticks come from `osc_tick_i`. Pin C carries the scan clock and pin A is an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Cascade mode, with the upper bit first |
| osc_tick_i | input | 1 | One-cycle scan tick from the internal oscillator divider |
| ext_clk_i | input | 1 | Scan clock from a master (pin A in slave mode) |
| image_i | input | 9*NUM_DIGITS | Latched display image |
| bp_a_o | output | 2 | Level code for backplane pin A |
| bp_b_o | output | 2 | Level code for backplane pin B |
| bp_c_o | output | 2 | Level code for pin C, or the scan clock |
| seg_o | output | 6*NUM_DIGITS | Segment level codes, 2 bits per line |
| bp_a_oe_o | output | 1 | Pin A drives a backplane |
| pin_c_clk_o | output | 1 | Pin C carries the scan clock |
| scan_clk_o | output | 1 | Scan clock that toggles on each tick |

## Verification
The frame-end copy of the image and a new value on `image_i` can occur on the same tick. The bench provokes this by changing the image on the very cycle it applies the last tick of a frame. It then requires the new image on the segment codes of the next frame. It also requires that an image changed one tick later has no effect until the following frame boundary. In slave mode, an oscillator pulse and an external clock edge can also arrive together. The bench judges this case by requiring that the scan position moves exactly once per external transition.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MIDL = 2'd1,
    LVL_MIDH = 2'd2,
    LVL_HIGH = 2'd3
  } lvl_e;

  localparam logic [1:0] MODE_MASTER = 2'b00;
  localparam logic [1:0] MODE_ALONE  = 2'b01;
  localparam logic [1:0] MODE_RSVD   = 2'b10;
  localparam logic [1:0] MODE_SLAVE  = 2'b11;

  localparam logic [1:0] PH_A = 2'd0;
  localparam logic [1:0] PH_B = 2'd1;
  localparam logic [1:0] PH_C = 2'd2;
endpackage

// File: rtl/lcd_tick_src.sv
module lcd_tick_src
  import lcd_scan_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       osc_tick_i,
  input  logic       ext_clk_i,
  output logic       tick_o
);
  logic [SYNC_STAGES:0] sync_q;
  logic                 ext_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk_i};
  end

  assign ext_edge = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
  assign tick_o   = (mode_i == MODE_SLAVE) ? ext_edge : osc_tick_i;

  AST_SLAVE_NO_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SLAVE && sync_q[SYNC_STAGES] == sync_q[SYNC_STAGES-1]) |-> !tick_o); // R11
endmodule

// File: rtl/lcd_frame_ctr.sv
module lcd_frame_ctr
  import lcd_scan_pkg::*;
#(
  parameter int PHASE_TICKS = 64,
  parameter int IMG_W       = 36
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [IMG_W-1:0] image_i,
  output logic [1:0]       phase_o,
  output logic             neg_o,
  output logic [IMG_W-1:0] shadow_o,
  output logic             scan_clk_o
);
  localparam int FRAME_TICKS = 3 * PHASE_TICKS;
  localparam int CW          = $clog2(FRAME_TICKS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_TICKS - 1);
  localparam logic [CW-1:0] P1   = CW'(PHASE_TICKS);
  localparam logic [CW-1:0] P2   = CW'(2 * PHASE_TICKS);
  localparam logic [CW-1:0] HALF = CW'(PHASE_TICKS / 2);

  logic [CW-1:0]    cnt_q, off;
  logic [IMG_W-1:0] shadow_q;
  logic             scan_q;
  logic             wrap;

  assign wrap = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      shadow_q <= '0;
      scan_q   <= 1'b0;
    end else if (tick_i) begin
      scan_q <= ~scan_q;
      if (wrap) begin
        cnt_q    <= '0;
        shadow_q <= image_i;  // frame-boundary copy only
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (cnt_q < P1) begin
      phase_o = PH_A;
      off     = cnt_q;
    end else if (cnt_q < P2) begin
      phase_o = PH_B;
      off     = cnt_q - P1;
    end else begin
      phase_o = PH_C;
      off     = cnt_q - P2;
    end
    neg_o = (off >= HALF);
  end

  assign shadow_o   = shadow_q;
  assign scan_clk_o = scan_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R1
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q != LAST) |=> cnt_q == CW'($past(cnt_q) + 1'b1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R1
  AST_NO_TEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(shadow_q)); // R7
  AST_SCAN_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> scan_q != $past(scan_q)); // R10
endmodule

// File: rtl/lcd_seg_map.sv
module lcd_seg_map
  import lcd_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic [9*NUM_DIGITS-1:0] img_i,
  input  logic [1:0]              phase_i,
  output logic [3*NUM_DIGITS-1:0] lit_o
);
  localparam int SP_BASE = 8 * NUM_DIGITS;

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    logic [7:0] b;
    assign b = img_i[8*d +: 8];
    always_comb begin
      unique case (phase_i)
        PH_A:    lit_o[3*d +: 3] = {b[2], b[7], b[6]};
        PH_B:    lit_o[3*d +: 3] = {b[3], b[1], b[5]};
        default: lit_o[3*d +: 3] = {img_i[SP_BASE + d], b[4], b[0]};
      endcase
    end
  end
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
  import lcd_scan_pkg::*;
#(
  parameter int NSEG = 12
) (
  input  logic [1:0]        mode_i,
  input  logic [1:0]        phase_i,
  input  logic              neg_i,
  input  logic [NSEG-1:0]   lit_i,
  input  logic              scan_clk_i,
  output logic [1:0]        bp_a_o,
  output logic [1:0]        bp_b_o,
  output logic [1:0]        bp_c_o,
  output logic [2*NSEG-1:0] seg_o,
  output logic              bp_a_oe_o,
  output logic              pin_c_clk_o
);
  lvl_e sel_lvl, idle_lvl, on_lvl, off_lvl;

  always_comb begin
    sel_lvl  = neg_i ? LVL_LOW  : LVL_HIGH;
    idle_lvl = neg_i ? LVL_MIDH : LVL_MIDL;
    on_lvl   = neg_i ? LVL_HIGH : LVL_LOW;
    off_lvl  = neg_i ? LVL_MIDL : LVL_MIDH;
  end

  assign bp_a_oe_o   = (mode_i == MODE_MASTER) || (mode_i == MODE_ALONE);
  assign pin_c_clk_o = (mode_i == MODE_MASTER) || (mode_i == MODE_RSVD);

  always_comb begin
    if (!bp_a_oe_o)             bp_a_o = LVL_LOW;
    else if (phase_i == PH_A)   bp_a_o = sel_lvl;
    else                        bp_a_o = idle_lvl;
    bp_b_o = (phase_i == PH_B) ? sel_lvl : idle_lvl;
    if (pin_c_clk_o)            bp_c_o = scan_clk_i ? LVL_HIGH : LVL_LOW;
    else if (phase_i == PH_C)   bp_c_o = sel_lvl;
    else                        bp_c_o = idle_lvl;
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    assign seg_o[2*i +: 2] = lit_i[i] ? on_lvl : off_lvl;
  end
endmodule

// File: rtl/lcd_triplex_scan.sv
module lcd_triplex_scan
  import lcd_scan_pkg::*;
#(
  parameter int NUM_DIGITS  = 4,
  parameter int PHASE_TICKS = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              mode_i,
  input  logic                    osc_tick_i,
  input  logic                    ext_clk_i,
  input  logic [9*NUM_DIGITS-1:0] image_i,
  output logic [1:0]              bp_a_o,
  output logic [1:0]              bp_b_o,
  output logic [1:0]              bp_c_o,
  output logic [6*NUM_DIGITS-1:0] seg_o,
  output logic                    bp_a_oe_o,
  output logic                    pin_c_clk_o,
  output logic                    scan_clk_o
);
  localparam int IMG_W = 9 * NUM_DIGITS;
  localparam int NSEG  = 3 * NUM_DIGITS;

  logic             tick;
  logic [1:0]       phase;
  logic             neg;
  logic [IMG_W-1:0] shadow;
  logic [NSEG-1:0]  lit;

  lcd_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i, .rst_ni, .mode_i, .osc_tick_i, .ext_clk_i, .tick_o(tick)
  );

  lcd_frame_ctr #(.PHASE_TICKS(PHASE_TICKS), .IMG_W(IMG_W)) u_ctr (
    .clk_i, .rst_ni, .tick_i(tick), .image_i,
    .phase_o(phase), .neg_o(neg), .shadow_o(shadow), .scan_clk_o
  );

  lcd_seg_map #(.NUM_DIGITS(NUM_DIGITS)) u_map (
    .img_i(shadow), .phase_i(phase), .lit_o(lit)
  );

  lcd_level_enc #(.NSEG(NSEG)) u_enc (
    .mode_i, .phase_i(phase), .neg_i(neg), .lit_i(lit), .scan_clk_i(scan_clk_o),
    .bp_a_o, .bp_b_o, .bp_c_o, .seg_o, .bp_a_oe_o, .pin_c_clk_o
  );

  AST_ONE_FULL_BP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_ALONE |-> $countones({bp_a_o == LVL_HIGH || bp_a_o == LVL_LOW,
                                          bp_b_o == LVL_HIGH || bp_b_o == LVL_LOW,
                                          bp_c_o == LVL_HIGH || bp_c_o == LVL_LOW}) == 1); // R2
  AST_PIN_A_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bp_a_oe_o |-> bp_a_o == LVL_LOW); // R11
  AST_PIN_C_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_c_clk_o |-> bp_c_o == (scan_clk_o ? LVL_HIGH : LVL_LOW)); // R10
endmodule

// File: tb/sim_lcd_triplex_scan.sv
module sim_lcd_triplex_scan;
  localparam int ND = 4;
  localparam int IW = 9 * ND;
  localparam int NS = 3 * ND;
  localparam int FR = 192;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b01;
  logic          osc = 1'b0;
  logic          ext = 1'b0;
  logic [IW-1:0] image = '0;
  logic [1:0]    bp_a, bp_b, bp_c;
  logic [2*NS-1:0] seg;
  logic          a_oe, c_clk, sclk;

  int errors = 0;
  int checks = 0;
  int e_cnt = 0;
  logic [IW-1:0] e_shadow = '0;
  logic e_par = 1'b0;

  always #4 clk = ~clk;

  lcd_triplex_scan u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .osc_tick_i(osc), .ext_clk_i(ext),
    .image_i(image), .bp_a_o(bp_a), .bp_b_o(bp_b), .bp_c_o(bp_c), .seg_o(seg),
    .bp_a_oe_o(a_oe), .pin_c_clk_o(c_clk), .scan_clk_o(sclk)
  );

  function automatic void model_tick();
    e_par = ~e_par;
    if (e_cnt == FR - 1) begin
      e_cnt = 0;
      e_shadow = image;
    end else e_cnt++;
  endfunction

  // image bit shown by line l of digit d in phase p (R4, R5)
  function automatic int bit_of(int d, int l, int p);
    int k;
    case (l)
      0: k = (p == 0) ? 6 : (p == 1) ? 5 : 0;
      1: k = (p == 0) ? 7 : (p == 1) ? 1 : 4;
      default: k = (p == 0) ? 2 : (p == 1) ? 3 : -1;
    endcase
    return (k < 0) ? 32 + d : 8 * d + k;
  endfunction

  function automatic logic [31:0] expect_vec();
    int p;
    logic n;
    logic [1:0] a, b, c, sel, idl, on, off;
    logic [2*NS-1:0] s;
    p = e_cnt / 64;
    n = (e_cnt % 64) >= 32;
    sel = n ? 2'd0 : 2'd3;
    idl = n ? 2'd2 : 2'd1;
    on  = n ? 2'd3 : 2'd0;
    off = n ? 2'd1 : 2'd2;
    a = (p == 0) ? sel : idl;
    b = (p == 1) ? sel : idl;
    c = (p == 2) ? sel : idl;
    if (!(mode == 2'b00 || mode == 2'b01)) a = 2'd0;
    if (mode == 2'b00 || mode == 2'b10) c = e_par ? 2'd3 : 2'd0;
    for (int d = 0; d < ND; d++)
      for (int l = 0; l < 3; l++)
        s[2*(3*d+l) +: 2] = e_shadow[bit_of(d, l, p)] ? on : off;
    return {(mode == 2'b00 || mode == 2'b01), (mode == 2'b00 || mode == 2'b10), a, b, c, s};
  endfunction

  task automatic chk(string req);
    logic [31:0] act, exp;
    act = {a_oe, c_clk, bp_a, bp_b, bp_c, seg};
    exp = expect_vec();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: tick=%0d actual=%h expected=%h", req, e_cnt, act, exp);
    end
  endtask

  task automatic advance(int n);
    for (int i = 0; i < n; i++) begin
      osc = 1'b1;
      if (mode != 2'b11) model_tick();
      @(negedge clk);
    end
    osc = 1'b0;
  endtask

  task automatic to_frame_end();
    advance(FR - e_cnt);
  endtask

  task automatic t_reset();
    chk("R8");
  endtask

  task automatic t_no_tear();
    image = 36'hF_FFFF_FFFF;
    advance(10);
    chk("R7");
    image = 36'h5_A5A5_A5A5;
    advance(70);
    chk("R7");
  endtask

  task automatic t_frame_shape();
    image = 36'h9_3C5A_0FF1;
    to_frame_end();
    chk("R1");
    advance(31); chk("R1");
    advance(1);  chk("R2");
    advance(31); chk("R3");
    advance(1);  chk("R1");
    advance(32); chk("R2");
    advance(32); chk("R1");
    advance(32); chk("R3");
  endtask

  task automatic t_walk();
    for (int k = 0; k < IW; k++) begin
      image = '0;
      image[k] = 1'b1;
      to_frame_end();
      chk((k >= 32) ? "R5" : "R4");
      advance(64); chk("R6");
      advance(64); chk((k >= 32) ? "R5" : "R4");
      advance(32); chk("R3");
    end
  endtask

  task automatic t_overlap();
    image = 36'h1_1111_1111;
    advance(FR - 1 - e_cnt);
    image = 36'hE_DCBA_9876;
    advance(1);
    chk("R7");
    image = 36'h0_0000_0001;
    advance(5);
    chk("R7");
    advance(64);
    chk("R7");
  endtask

  task automatic t_modes();
    mode = 2'b00;
    advance(1); chk("R10");
    advance(1); chk("R10");
    advance(3); chk("R10");
    mode = 2'b10;
    advance(1); chk("R12");
    advance(2); chk("R12");
    mode = 2'b01;
    advance(1); chk("R9");
  endtask

  task automatic t_slave();
    mode = 2'b11;
    @(negedge clk);
    chk("R11");
    advance(20);
    chk("R11");
    for (int i = 0; i < 40; i++) begin
      ext = ~ext;
      osc = 1'b1;
      model_tick();
      repeat (4) @(negedge clk);
      osc = 1'b0;
    end
    chk("R11");
    mode = 2'b01;
    @(negedge clk);
    chk("R9");
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_tear();
    t_frame_shape();
    t_walk();
    t_overlap();
    t_modes();
    t_slave();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule